// File: doc/BRIEF.md
# Selectable-Source Timer Counter

This block is an up-counter for a small microcontroller core. It appears on the register bus as a data register. It advances by one on a tick. A tick is either each instruction-cycle strobe or a chosen edge of an external timer pin. Two control bits choose the tick source and, in pin mode, the active edge.

The external pin is asynchronous. It passes through a chain of synchronizer flops before anything looks at it. The synchronized level is then sampled once per instruction cycle, so a pin level only counts if it lasts longer than one instruction cycle. Software can read the counter at any time and overwrite it. When the counter rolls over to zero it emits a one-clock pulse, which a neighbouring interrupt block can use.

Top module: `timer_tick_counter`

## Requirements
- R1: Reset (`rst_n` low, asynchronous) sets the count to 0x00 and holds `ovf_pulse` low.
- R2: With `src_ext` low (control bit 5 clear), the count rises by one on every clock edge where `cyc_en` is high. It holds on every edge where `cyc_en` is low.
- R3: With `src_ext` high (control bit 5 set), instruction-cycle strobes alone do not advance the count while the pin is static.
- R4: In pin mode, `edge_fall` (control bit 4) picks the counted edge: 0 counts rising edges, 1 counts falling edges. The opposite edge leaves the count unchanged.
- R5: A pin level held longer than one instruction cycle produces exactly one count for its active edge. The pin goes through two synchronizer flops and is sampled on `cyc_en`, so the count changes no sooner than the third clock edge after the pin moves.
- R6: When `wr_en` is high, `wr_data` is loaded on the next clock edge. This takes priority over any tick in the same cycle, and `rd_data` shows the written value from the following cycle on.
- R7: A tick at 0xFF wraps the count to 0x00 and raises `ovf_pulse` for exactly one clock, in the cycle after the wrap edge. A write never raises `ovf_pulse`.
- R8: `rd_data` always equals the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One-clock strobe per instruction cycle |
| ext_pin | input | 1 | Asynchronous external timer input |
| src_ext | input | 1 | Control bit 5: 0 instruction clock, 1 external pin |
| edge_fall | input | 1 | Control bit 4: 0 rising edge, 1 falling edge |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | WIDTH | Value to load |
| rd_data | output | WIDTH | Current count |
| ovf_pulse | output | 1 | One-clock pulse after a wrap to zero |

## Verification
The assertions assume that `cyc_en` is a single-clock strobe. They also assume that `src_ext` and `edge_fall` change only while the pin is settled, so that no edge is in flight through the synchronizer. The bench drives every input on the falling clock edge. It changes the control bits only after the pin has been static for several clocks. It holds each pin level for more than one instruction cycle, so every edge it expects to count is one the design is obliged to count.

// File: rtl/timer_tick_counter.sv
module timer_tick_counter #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             ext_pin,
  input  logic             src_ext,
  input  logic             edge_fall,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             ovf_pulse
);

  localparam logic [WIDTH-1:0] MAXV = '1;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_prev;
  logic [WIDTH-1:0]       cnt;
  logic                   ovf_q;

  wire pin_s    = sync_q[SYNC_STAGES-1];
  wire ext_edge = edge_fall ? (pin_prev & ~pin_s) : (~pin_prev & pin_s);
  wire tick     = cyc_en & (src_ext ? ext_edge : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      pin_prev <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_pin};
      if (cyc_en) pin_prev <= pin_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= !wr_en && tick && (cnt == MAXV);
      if (wr_en)     cnt <= wr_data;
      else if (tick) cnt <= cnt + ONE;
    end
  end

  assign rd_data   = cnt;
  assign ovf_pulse = ovf_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (rd_data == '0 || !rst_n)); // R1
  AST_INT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cyc_en && !src_ext) |=> rd_data == $past(rd_data) + ONE); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cyc_en) |=> $stable(rd_data)); // R2
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data)); // R6
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (rd_data == '0 && !$past(wr_en))); // R7
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse); // R7

endmodule

// File: tb/sim_timer_tick_counter.sv
module sim_timer_tick_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0, ext_pin = 1'b0, src_ext = 1'b0, edge_fall = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ovf_pulse;
  int         n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  timer_tick_counter #(.WIDTH(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .src_ext(src_ext), .edge_fall(edge_fall), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ovf_pulse(ovf_pulse));

  // {wr_en, wr_data, cyc_en, expected count, expected ovf}, internal source
  localparam logic [18:0] VEC [12] = '{
    {1'b0, 8'h00, 1'b1, 8'h01, 1'b0},
    {1'b0, 8'h00, 1'b0, 8'h01, 1'b0},
    {1'b1, 8'hFD, 1'b1, 8'hFD, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'hFE, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'hFF, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'h00, 1'b1},
    {1'b0, 8'h00, 1'b0, 8'h00, 1'b0},
    {1'b1, 8'hFF, 1'b0, 8'hFF, 1'b0},
    {1'b1, 8'hFF, 1'b1, 8'hFF, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'h00, 1'b1},
    {1'b1, 8'h5A, 1'b0, 8'h5A, 1'b0},
    {1'b0, 8'h00, 1'b1, 8'h5B, 1'b0}
  };

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got count=%h ovf=%b, expected count=%h ovf=%b",
               req, act[8:1], act[0], exp[8:1], exp[0]);
    end
  endtask

  task automatic step(logic cyc, logic wr, logic [7:0] wd);
    @(negedge clk);
    cyc_en = cyc; wr_en = wr; wr_data = wd;
    @(negedge clk);
    cyc_en = 1'b0; wr_en = 1'b0;
  endtask

  // n clocks, strobe on every period-th clock
  task automatic run(int n, int period);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc_en = (i % period == period - 1);
    end
    @(negedge clk);
    cyc_en = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] base;
    repeat (3) @(negedge clk);
    check("R1 reset", {rd_data, ovf_pulse}, {8'h00, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {rd_data, ovf_pulse}, {8'h00, 1'b0});

    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      cyc_en = VEC[k][9]; wr_en = VEC[k][18]; wr_data = VEC[k][17:10];
      @(negedge clk);
      cyc_en = 1'b0; wr_en = 1'b0;
      check($sformatf("R2/R6/R7/R8 vector %0d", k), {rd_data, ovf_pulse}, VEC[k][8:0]);
    end

    // external source, rising edge
    step(1'b0, 1'b1, 8'h10);
    src_ext = 1'b1; edge_fall = 1'b0;
    run(6, 1);
    check("R3 strobes ignored, static pin", {rd_data, ovf_pulse}, {8'h10, 1'b0});
    @(negedge clk); ext_pin = 1'b1;
    cyc_en = 1'b1;
    @(negedge clk);
    check("R5 no count after 1st edge", {rd_data, ovf_pulse}, {8'h10, 1'b0});
    @(negedge clk);
    check("R5 no count after 2nd edge", {rd_data, ovf_pulse}, {8'h10, 1'b0});
    @(negedge clk);
    check("R5 count after 3rd edge", {rd_data, ovf_pulse}, {8'h11, 1'b0});
    run(5, 1);
    check("R4 rising counted once", {rd_data, ovf_pulse}, {8'h11, 1'b0});
    ext_pin = 1'b0;
    run(6, 1);
    check("R4 falling ignored in rising mode", {rd_data, ovf_pulse}, {8'h11, 1'b0});

    // falling edge mode
    edge_fall = 1'b1;
    ext_pin = 1'b1;
    run(6, 1);
    check("R4 rising ignored in falling mode", {rd_data, ovf_pulse}, {8'h11, 1'b0});
    ext_pin = 1'b0;
    run(6, 1);
    check("R4 falling counted", {rd_data, ovf_pulse}, {8'h12, 1'b0});

    // slow instruction cycle: level held 8 clocks, strobe every 4
    edge_fall = 1'b0;
    base = rd_data;
    ext_pin = 1'b1;
    run(8, 4);
    ext_pin = 1'b0;
    run(8, 4);
    check("R5 long level counted once", {rd_data, ovf_pulse}, {base + 8'h01, 1'b0});

    // wrap in pin mode
    step(1'b0, 1'b1, 8'hFF);
    ext_pin = 1'b1;
    @(negedge clk); cyc_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 pin wrap with pulse", {rd_data, ovf_pulse}, {8'h00, 1'b1});
    @(negedge clk);
    check("R7 pulse lasts one clock", {rd_data, ovf_pulse}, {8'h00, 1'b0});
    cyc_en = 1'b0;
    ext_pin = 1'b0;
    run(4, 1);

    // back to internal source
    src_ext = 1'b0;
    step(1'b1, 1'b0, 8'h00);
    check("R2 internal after switch", {rd_data, ovf_pulse}, {8'h01, 1'b0});

    // reset mid-run
    step(1'b0, 1'b1, 8'hA5);
    #3 rst_n = 1'b0;
    #1;
    check("R1 async reset mid-run", {rd_data, ovf_pulse}, {8'h00, 1'b0});
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule